// File: doc/BRIEF.md
# Framed SPI DAC Word Receiver

This block is the receiving end of a three-wire serial link that loads a code into a voltage-output DAC. A host lowers an active-low chip select, shifts the code in most significant bit first on the rising edges of the serial clock, and then raises chip select. The block brings the three serial wires into its own system clock domain, counts the serial clock edges seen in each frame and shifts in the data bits. It decides whether the frame counts only when chip select goes high.

A frame that reaches the full frame length produces a one-cycle ready strobe together with the captured code. A frame that stops short is dropped with no effect. A frame that runs longer keeps the bits received first. A compile-time parameter selects between two configurations. The narrow one takes a 16-bit code in a 16-clock frame. The wide one takes a 20-bit code in a 24-clock frame, and the four trailing clocks of that frame carry padding that is ignored.

Top module: `spi_dac_word_rx`

## Requirements
- R1: After reset `word_o` is all zeros and `word_rdy_o` is low.
- R2: While `cs_n` is low, each rising edge of `sclk` samples `mosi`. The first bit sampled becomes the most significant bit of the code. The system clock must run at least four times as fast as `sclk`.
- R3: With `WIDE_MODE=0` a frame has 16 `sclk` rising edges, and all 16 bits sampled form `word_o[15:0]`.
- R4: With `WIDE_MODE=1` a frame has 24 `sclk` rising edges. The first 20 bits form `word_o[19:0]`, and the values of the last 4 bits have no effect on `word_o`.
- R5: `word_rdy_o` rises only in response to a rising edge of `cs_n`. It goes high on the third rising `clk` edge after `cs_n` rises, counting from the first edge that samples `cs_n` high.
- R6: A frame with fewer `sclk` rising edges than the frame length produces no strobe and leaves `word_o` unchanged.
- R7: A frame with more rising edges than the frame length produces a strobe. The code holds the first bits received, and all later bits are ignored.
- R8: `word_rdy_o` is high for exactly one `clk` cycle per qualifying frame. `word_o` changes only in the cycle that `word_rdy_o` is high.
- R9: `sclk` edges that occur while `cs_n` is high are ignored. The edge count restarts from zero in every frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| word_o | output | CODE_W (16 or 20) | Last accepted DAC code |
| word_rdy_o | output | 1 | One-cycle strobe marking a newly accepted code |

## Verification
The bench builds two copies of the block that share the same serial wires, one with `WIDE_MODE=1` and one with `WIDE_MODE=0`. Each frame is therefore judged under both frame lengths. A 16-edge frame is exact for the narrow copy and short for the wide copy. A 24-edge frame is exact for the wide copy and overlong for the narrow copy. Frames of 23 and 28 edges sit on each side of the wide boundary. Changing only the padding bits shows that they have no effect. Serial clock activity while chip select is high shows that the edge count restarts in each frame.

// File: rtl/spi_dac_rx_pkg.sv
package spi_dac_rx_pkg;

  function automatic int unsigned code_bits(input bit wide);
    return wide ? 20 : 16;
  endfunction

  function automatic int unsigned frame_edges(input bit wide);
    return wide ? 24 : 16;
  endfunction

  function automatic int unsigned count_bits(input bit wide);
    return $clog2(frame_edges(wide) + 1);
  endfunction

endpackage

// File: rtl/sdr_sync.sv
module sdr_sync #(
  parameter int unsigned     N       = 3,
  parameter logic [N-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/sdr_edge_ctr.sv
module sdr_edge_ctr #(
  parameter int unsigned LIMIT = 24,
  parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle_i,
  input  logic          edge_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_o <= '0;
    else if (idle_i)                cnt_o <= '0;
    else if (edge_i && cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
  end

  // R9
  ctr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i |=> (cnt_o == '0));

  // R7
  ctr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= TOP);
endmodule

// File: rtl/sdr_shifter.sv
module sdr_shifter #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_i,
  input  logic         bit_i,
  output logic [W-1:0] sh_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh_o <= '0;
    else if (take_i) sh_o <= {sh_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/spi_dac_word_rx.sv
module spi_dac_word_rx
  import spi_dac_rx_pkg::*;
#(
  parameter bit WIDE_MODE = 1'b1,
  parameter int unsigned CODE_W = code_bits(WIDE_MODE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  output logic [CODE_W-1:0] word_o,
  output logic              word_rdy_o
);
  localparam int unsigned FRAME_N = frame_edges(WIDE_MODE);
  localparam int unsigned CNT_W   = count_bits(WIDE_MODE);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_N);
  localparam logic [CNT_W-1:0] DATA = CNT_W'(CODE_W);

  logic [2:0] pins_s;
  logic cs_s, sclk_s, mosi_s;
  logic sclk_d, cs_d;
  logic sclk_rise, cs_rise, frame_full, take_bit;
  logic [CNT_W-1:0] edge_cnt;
  logic [CODE_W-1:0] shift_q;

  sdr_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({cs_n, sclk, mosi}), .q_o(pins_s)
  );
  assign {cs_s, sclk_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  assign sclk_rise  = sclk_s & ~sclk_d & ~cs_s;
  assign cs_rise    = cs_s & ~cs_d;
  assign take_bit   = sclk_rise && (edge_cnt < DATA);
  assign frame_full = (edge_cnt == FULL);

  sdr_edge_ctr #(.LIMIT(FRAME_N), .CW(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .idle_i(cs_s), .edge_i(sclk_rise), .cnt_o(edge_cnt)
  );

  sdr_shifter #(.W(CODE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .take_i(take_bit), .bit_i(mosi_s), .sh_o(shift_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o     <= '0;
      word_rdy_o <= 1'b0;
    end else begin
      word_rdy_o <= cs_rise && frame_full;
      if (cs_rise && frame_full) word_o <= shift_q;
    end
  end

  // R8
  rdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_rdy_o |=> !word_rdy_o);

  // R5
  rdy_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_rdy_o) |-> $past(cs_rise));

  // R6
  rdy_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_rdy_o |-> $past(edge_cnt) == FULL);

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_o) |-> word_rdy_o);
endmodule

// File: tb/spi_dac_word_rx_tb.sv
module spi_dac_word_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic [19:0] w20;
  logic [15:0] w16;
  logic r20, r16;
  int checks = 0, errors = 0;
  logic [19:0] exp20 = '0;
  logic [15:0] exp16 = '0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_dac_word_rx #(.WIDE_MODE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .word_o(w20), .word_rdy_o(r20));
  spi_dac_word_rx #(.WIDE_MODE(1'b0)) u_dut_n (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .word_o(w16), .word_rdy_o(r16));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_sclk();
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  // R2 R3 R4 R5 R6 R7 R8: one frame, judged under both frame lengths
  task automatic send_frame(input string tag, input int nedges, input logic [31:0] bits);
    bit q20, q16;
    q20 = (nedges >= 24);
    q16 = (nedges >= 16);
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < nedges; i++) begin
      mosi = bits[31 - i];
      pulse_sclk();
      chk({tag, " R5 no strobe while cs low (wide)"}, 32'(r20), 0);
      chk({tag, " R5 no strobe while cs low (narrow)"}, 32'(r16), 0);
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    if (q20) exp20 = bits[31:12];
    if (q16) exp16 = bits[31:16];
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk($sformatf("%s R5 R8 wide strobe k=%0d", tag, k), 32'(r20), 32'(q20 && k == 3));
      chk($sformatf("%s R5 R8 narrow strobe k=%0d", tag, k), 32'(r16), 32'(q16 && k == 3));
    end
    chk({tag, " R4 R6 R7 wide word"}, 32'(w20), 32'(exp20));
    chk({tag, " R3 R6 R7 narrow word"}, 32'(w16), 32'(exp16));
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 wide word", 32'(w20), 0);
    chk("R1 narrow word", 32'(w16), 0);
    chk("R1 wide strobe", 32'(r20), 0);
    chk("R1 narrow strobe", 32'(r16), 0);
  endtask

  task automatic t_idle_clocks();
    // R9: edges with cs_n high must not count toward the next frame
    for (int i = 0; i < 12; i++) begin
      mosi = i[0];
      pulse_sclk();
    end
    chk("R9 wide strobe idle", 32'(r20), 0);
    chk("R9 narrow strobe idle", 32'(r16), 0);
    send_frame("R9 idle+10", 10, 32'hFFFF_FFFF);
    send_frame("R9 idle+14", 14, 32'h0000_0000);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog actual=hung expected=done");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    send_frame("R3 exact16", 16, 32'hA5C3_0000);
    send_frame("R4 exact24", 24, 32'h3C5A_9E70);
    send_frame("R4 pad ones", 24, 32'h0000_1F00);
    send_frame("R4 pad zero", 24, 32'h0000_1000);
    send_frame("R6 short15", 15, 32'hFFFF_FFFF);
    send_frame("R6 R7 edges23", 23, 32'h1234_5600);
    send_frame("R7 over28", 28, 32'hC3A5_F0E0);
    t_idle_clocks();
    send_frame("R2 after idle", 24, 32'h8000_1000);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule